// File: doc/BRIEF.md
# Multi-Serializer Shared-Port Sequencer

This block connects one memory-mapped data port, served by a DMA engine or a CPU, to a bank of audio serializers. Each serializer can be enabled or disabled, and each can be set to transmit or to receive. Software always uses the same port address. The block decides which serializer each access belongs to. It walks through the enabled serializers of the matching direction, in rising index order, and skips the ones that are disabled.

Each serializer keeps a holding register per direction. A one-cycle slot strobe marks a slot boundary. On that strobe, every transmit serializer loads its word for the slot and every receive serializer captures its incoming word. After the strobe, the block pulses a transmit-ready event and a receive-ready event. If a slot boundary arrives before every transmit serializer has been written, the block raises a sticky underrun flag. If it arrives before every receive serializer has been read, the block raises a sticky overrun flag. A bus-select input turns the shared port off. Shifting, bit clocks and frame sync are handled outside this block.

Top module: `sdp_port_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `tx_ready`, `rx_ready`, `underrun` and `overrun` are 0 and every word of `tx_out` is 0.
- R2: Writes accepted after a transmit-ready event fill the transmit holding registers in rising order of serializer index. Only serializers with `cfg_active=1` and `cfg_dir=1` receive writes. On the next `slot_strobe`, each written word appears at its serializer's `tx_out` slice (bits [32*i+31:32*i] for serializer i).
- R3: After a receive-ready event, each accepted read advances through the serializers with `cfg_active=1` and `cfg_dir=0`, in rising index order. Before the read, `port_rdata` already shows the word that the current serializer captured from `rx_in` on the last strobe.
- R4: `tx_ready` is a one-cycle pulse. It appears in the first cycle after reset is released and in the cycle after each `slot_strobe`, but only when at least one transmit serializer is enabled. Each pulse restarts the write sequence at the lowest enabled transmit index.
- R5: `rx_ready` pulses in the cycle after each `slot_strobe` when at least one receive serializer is enabled. The pulse restarts the read sequence at the lowest enabled receive index.
- R6: A `slot_strobe` that arrives while an enabled transmit serializer is still unwritten sets `underrun`. Every such serializer drives 0 on `tx_out` for that slot.
- R7: A `slot_strobe` that arrives while an enabled receive serializer is still unread sets `overrun`.
- R8: While `cfg_bussel=1`, writes and reads on the port are ignored and do not advance either sequence.
- R9: Once every transmit serializer has been written in a slot, further writes are ignored. Once every receive serializer has been read in a slot, further reads are ignored and `port_rdata` reads 0.
- R10: `underrun` and `overrun` stay set until `err_clr` is pulsed. If a new error occurs in the same cycle as the clear, the flag stays set.
- R11: A direction with no enabled serializers never pulses its ready output and never raises its error flag.
- R12: The `tx_out` slice of any serializer that is disabled or set to receive is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | 16 | 1 = serializer enabled; change only while the port is idle |
| cfg_dir | input | 16 | 1 = transmit, 0 = receive |
| cfg_bussel | input | 1 | 1 = shared data port disabled |
| slot_strobe | input | 1 | Slot boundary: load transmit words, capture receive words |
| rx_in | input | 512 | Incoming word per serializer, 32 bits each |
| port_wr | input | 1 | Write strobe on the shared port |
| port_wdata | input | 32 | Write data |
| port_rd | input | 1 | Read strobe on the shared port |
| port_rdata | output | 32 | Word of the current receive serializer, 0 when none is left |
| tx_out | output | 512 | Word loaded into each serializer for the current slot |
| tx_ready | output | 1 | Transmit data-ready pulse |
| rx_ready | output | 1 | Receive data-ready pulse |
| underrun | output | 1 | Sticky transmit underrun flag |
| overrun | output | 1 | Sticky receive overrun flag |
| err_clr | input | 1 | Clears both sticky flags |

## Verification
The bench runs through a set of enable and direction masks. The set covers sparse masks with gaps, single-bit masks at every position, full masks and empty masks. For each mask, the bench computes the expected rising-order sequence itself.

Several faults are targeted:
- Descending order, or not skipping gaps, would put words in the wrong `tx_out` slices or return words in the wrong order.
- Acting on a port access while bus-select is 1 would shift every later word by one serializer.
- Accepting writes beyond the last serializer would overwrite a word that was already placed.
- Forgetting the zero fill on underrun would replay the previous slot's words.
- Flags that are not sticky, or that fire for an empty direction, show up in the strobes with no service and the strobes with service skipped.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int SDP_NSER = 16;
  localparam int SDP_DW   = 32;

  typedef struct packed {
    logic urun;
    logic ovrn;
  } sdp_err_t;
endpackage

// File: rtl/sdp_lowest.sv
module sdp_lowest #(
  parameter  int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          vld
);
  always_comb begin
    idx = '0;
    vld = |req;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/sdp_tx_path.sv
module sdp_tx_path #(
  parameter int NSER = 16,
  parameter int DW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             strobe,
  input  logic [NSER-1:0]  txmask,
  input  logic             acc_wr,
  input  logic [DW-1:0]    wdata,
  output logic [NSER*DW-1:0] tx_out,
  output logic [NSER-1:0]  pend,
  output logic             urun_evt
);
  localparam int IW = (NSER > 1) ? $clog2(NSER) : 1;

  logic [NSER-1:0] pend_q, pend_d;
  logic [IW-1:0]   wptr;
  logic            wvld;
  logic            wen;
  logic [NSER-1:0] below_ptr;

  sdp_lowest #(.N(NSER)) i_wsel (.req(pend_q), .idx(wptr), .vld(wvld));

  assign wen       = acc_wr && wvld && !evt;
  assign urun_evt  = strobe && (|pend_q);
  assign pend      = pend_q;
  assign below_ptr = (NSER'(1) << wptr) - NSER'(1);

  always_comb begin
    pend_d = pend_q;
    if (evt)      pend_d = txmask;
    else if (wen) pend_d[wptr] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar g = 0; g < NSER; g++) begin : g_lane
    logic [DW-1:0] hold_q, hold_d, out_q, out_d;

    always_comb begin
      hold_d = hold_q;
      if (wen && (wptr == IW'(g))) hold_d = wdata;
      out_d = out_q;
      if (strobe) out_d = (txmask[g] && !pend_q[g]) ? hold_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        out_q  <= '0;
      end else begin
        hold_q <= hold_d;
        out_q  <= out_d;
      end
    end

    assign tx_out[g*DW +: DW] = out_q;

    AST_TX_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && pend_q[g]) |=> (out_q == '0)); // R6
  end

  AST_TX_ONE_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wen |=> ($countones(pend_q) + 1 == $countones($past(pend_q)))); // R2
  AST_TX_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wen |-> ((pend_q & below_ptr) == '0)); // R2
endmodule

// File: rtl/sdp_rx_path.sv
module sdp_rx_path #(
  parameter int NSER = 16,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic [NSER-1:0]    rxmask,
  input  logic [NSER*DW-1:0] rx_in,
  input  logic               acc_rd,
  output logic [DW-1:0]      rdata,
  output logic [NSER-1:0]    pend,
  output logic               ovrn_evt
);
  localparam int IW = (NSER > 1) ? $clog2(NSER) : 1;

  logic [NSER-1:0]    pend_q, pend_d;
  logic [IW-1:0]      rptr;
  logic               rvld;
  logic               ren;
  logic [NSER*DW-1:0] cap_flat;

  sdp_lowest #(.N(NSER)) i_rsel (.req(pend_q), .idx(rptr), .vld(rvld));

  assign ren      = acc_rd && rvld && !strobe;
  assign ovrn_evt = strobe && (|pend_q);
  assign pend     = pend_q;

  always_comb begin
    pend_d = pend_q;
    if (strobe)   pend_d = rxmask;
    else if (ren) pend_d[rptr] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar g = 0; g < NSER; g++) begin : g_lane
    logic [DW-1:0] cap_q, cap_d;

    always_comb begin
      cap_d = cap_q;
      if (strobe && rxmask[g]) cap_d = rx_in[g*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= '0;
      else        cap_q <= cap_d;
    end

    assign cap_flat[g*DW +: DW] = cap_q;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NSER; k++) begin
      if (rvld && (rptr == IW'(k))) rdata = cap_flat[k*DW +: DW];
    end
  end

  AST_RX_ONE_PER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ren |=> ($countones(pend_q) + 1 == $countones($past(pend_q)))); // R3
  AST_RX_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (rdata == '0)); // R9
endmodule

// File: rtl/sdp_port_seq.sv
module sdp_port_seq
  import sdp_pkg::*;
#(
  parameter int NSER = SDP_NSER,
  parameter int DW   = SDP_DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSER-1:0]    cfg_active,
  input  logic [NSER-1:0]    cfg_dir,
  input  logic               cfg_bussel,
  input  logic               slot_strobe,
  input  logic [NSER*DW-1:0] rx_in,
  input  logic               port_wr,
  input  logic [DW-1:0]      port_wdata,
  input  logic               port_rd,
  output logic [DW-1:0]      port_rdata,
  output logic [NSER*DW-1:0] tx_out,
  output logic               tx_ready,
  output logic               rx_ready,
  output logic               underrun,
  output logic               overrun,
  input  logic               err_clr
);
  logic [NSER-1:0] txmask, rxmask, tx_pend, rx_pend;
  logic            boot_q, boot_d;
  logic            tx_evt;
  logic            txr_q, txr_d, rxr_q, rxr_d;
  sdp_err_t        err_q, err_d, err_new;
  logic            acc_wr, acc_rd;

  assign txmask = cfg_active & cfg_dir;
  assign rxmask = cfg_active & ~cfg_dir;
  assign tx_evt = slot_strobe || boot_q;
  assign acc_wr = port_wr && !cfg_bussel;
  assign acc_rd = port_rd && !cfg_bussel;

  sdp_tx_path #(.NSER(NSER), .DW(DW)) i_tx (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt), .strobe(slot_strobe),
    .txmask(txmask), .acc_wr(acc_wr), .wdata(port_wdata),
    .tx_out(tx_out), .pend(tx_pend), .urun_evt(err_new.urun)
  );

  sdp_rx_path #(.NSER(NSER), .DW(DW)) i_rx (
    .clk(clk), .rst_n(rst_n), .strobe(slot_strobe), .rxmask(rxmask),
    .rx_in(rx_in), .acc_rd(acc_rd), .rdata(port_rdata),
    .pend(rx_pend), .ovrn_evt(err_new.ovrn)
  );

  always_comb begin
    boot_d = 1'b0;
    txr_d  = tx_evt && (|txmask);
    rxr_d  = slot_strobe && (|rxmask);
    err_d  = err_clr ? err_new : (err_q | err_new);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      txr_q  <= 1'b0;
      rxr_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      boot_q <= boot_d;
      txr_q  <= txr_d;
      rxr_q  <= rxr_d;
      err_q  <= err_d;
    end
  end

  assign tx_ready = txr_q;
  assign rx_ready = rxr_q;
  assign underrun = err_q.urun;
  assign overrun  = err_q.ovrn;

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !err_clr) |=> underrun); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun); // R10
  AST_BUSSEL_FREEZE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bussel && !tx_evt) |=> $stable(tx_pend)); // R8
  AST_BUSSEL_FREEZE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bussel && !slot_strobe) |=> $stable(rx_pend)); // R8
  AST_TX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_pend == txmask)); // R4
  AST_NO_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (txmask == '0) |-> (!tx_ready && (tx_pend == '0))); // R11
endmodule

// File: tb/test_sdp_port_seq.sv
module test_sdp_port_seq;
  localparam int NS = 16;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NS-1:0]  cfg_active, cfg_dir;
  logic           cfg_bussel, slot_strobe, port_wr, port_rd, err_clr;
  logic [NS*DW-1:0] rx_in, tx_out;
  logic [DW-1:0]  port_wdata, port_rdata;
  logic           tx_ready, rx_ready, underrun, overrun;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdp_port_seq i_sdp_port_seq (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_dir(cfg_dir),
    .cfg_bussel(cfg_bussel), .slot_strobe(slot_strobe), .rx_in(rx_in),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rd(port_rd),
    .port_rdata(port_rdata), .tx_out(tx_out), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .underrun(underrun), .overrun(overrun),
    .err_clr(err_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] txw(input int c, input int i);
    return 32'hA000_0000 | (32'(c) << 8) | 32'(i);
  endfunction

  function automatic logic [31:0] rxw(input int c, input int i);
    return 32'h5000_0000 | (32'(c) << 8) | 32'(i);
  endfunction

  task automatic run_cfg(input int c, input logic [NS-1:0] act, input logic [NS-1:0] dir);
    logic [NS-1:0] txm, rxm;
    txm = act & dir;
    rxm = act & ~dir;
    cfg_active = act; cfg_dir = dir;
    cfg_bussel = 0; slot_strobe = 0; port_wr = 0; port_rd = 0; err_clr = 0;
    port_wdata = '0;
    for (int i = 0; i < NS; i++) rx_in[i*DW +: DW] = rxw(c, i);
    rst_n = 0;
    #12;
    check("R1 tx_ready in reset", 32'(tx_ready), 0);
    check("R1 tx_out in reset", 32'(|tx_out), 0);
    @(posedge clk); #1 rst_n = 1;
    check("R1 flags after release", {28'd0, tx_ready, rx_ready, underrun, overrun}, 0);
    check("R1 tx_out after release", 32'(|tx_out), 0);
    step();
    check("R4/R11 first tx_ready", 32'(tx_ready), 32'(txm != 0));
    check("R5 rx_ready at start", 32'(rx_ready), 0);
    // R8: a port write while disabled must not consume a serializer
    cfg_bussel = 1; port_wr = 1; port_wdata = 32'hDEAD_0000;
    step();
    check("R4 tx_ready single pulse", 32'(tx_ready), 0);
    cfg_bussel = 0;
    for (int i = 0; i < NS; i++) begin
      if (txm[i]) begin
        port_wdata = txw(c, i);
        step();
      end
    end
    // R9: one extra write after all serializers are filled
    port_wdata = 32'hBEEF_0000;
    step();
    port_wr = 0;
    slot_strobe = 1;
    step();
    slot_strobe = 0;
    for (int i = 0; i < NS; i++)
      check(txm[i] ? "R2 tx word placement" : "R12 idle lane zero",
            tx_out[i*DW +: DW], txm[i] ? txw(c, i) : 32'd0);
    check("R4/R11 tx_ready after strobe", 32'(tx_ready), 32'(txm != 0));
    check("R5/R11 rx_ready after strobe", 32'(rx_ready), 32'(rxm != 0));
    check("R6 no underrun when served", 32'(underrun), 0);
    // R8: a read while disabled must not advance
    cfg_bussel = 1; port_rd = 1;
    step();
    cfg_bussel = 0;
    for (int i = 0; i < NS; i++) begin
      if (rxm[i]) begin
        check("R3 read order", port_rdata, rxw(c, i));
        step();
      end
    end
    check("R9 rdata after last read", port_rdata, 0);
    step();
    port_rd = 0;
    check("R9 rdata stays zero", port_rdata, 0);
    // strobe with no transmit service
    slot_strobe = 1;
    step();
    slot_strobe = 0;
    check("R6/R11 underrun flagged", 32'(underrun), 32'(txm != 0));
    check("R6 zero fill on underrun", 32'(|tx_out), 0);
    check("R7 no overrun when read", 32'(overrun), 0);
    step();
    check("R10 underrun sticky", 32'(underrun), 32'(txm != 0));
    slot_strobe = 1;
    step();
    slot_strobe = 0;
    check("R7/R11 overrun flagged", 32'(overrun), 32'(rxm != 0));
    err_clr = 1;
    step();
    err_clr = 0;
    check("R10 flags cleared", {30'd0, underrun, overrun}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    run_cfg(1, 16'h00B1, 16'h00B1);
    run_cfg(2, 16'h004E, 16'h0000);
    run_cfg(3, 16'h00FF, 16'h00B1);
    run_cfg(4, 16'hFFFF, 16'hAAAA);
    run_cfg(5, 16'h8001, 16'h8000);
    run_cfg(6, 16'h0000, 16'h0000);
    run_cfg(7, 16'hFFFF, 16'hFFFF);
    run_cfg(8, 16'hFFFF, 16'h0000);
    run_cfg(9, 16'h1234, 16'hFF00);
    run_cfg(10, 16'h0011, 16'hFFFF);
    for (int b = 0; b < NS; b++) run_cfg(16 + b, 16'(1) << b, 16'((b % 2) != 0) << b);
    for (int b = 0; b < NS; b++) run_cfg(40 + b, ~(16'(1) << b), 16'h5A5A);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule